// File: doc/BRIEF.md
# Free-Running Compare Timer

This block is a memory-mapped general-purpose timer. It holds an up-counter that advances on ticks taken from one of several clock sources. Each source arrives as a one-cycle enable pulse that is synchronous to the system clock. One output-compare channel raises a status flag when the counter reaches the compare value. An interrupt-enable bit gates that flag onto a level interrupt line.

Ticks pass through two divide stages. The first is an oscillator stage, used only when the oscillator source is chosen. It divides by a fixed eight, or by a programmable N+1 when its own enable bit is set. The second is a main divider that all sources share, with a programmable ratio P+1.

Software runs the timer through a simple 32-bit register bus. Reads are combinational and writes take effect at the clock edge. The counter either free-runs through the compare value, or restarts from zero after it.

Top module: `gpt_cmp_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: The counter advances only while control bit 0 (enable) is 1. While enable is 0, the counter is held at 0 and both dividers restart.
- R3: Control bits 8:6 choose the tick source: code 1 is `tick_bus`, code 2 is `tick_per` and code 5 is the oscillator path. Any other code delivers no ticks.
- R4: Prescaler bits 11:0 (P) give one counter advance per P+1 source ticks. A write that changes P restarts the main divider from zero.
- R5: On the oscillator path, `tick_osc` is divided by N+1, where N is prescaler bits 15:12, when control bit 10 is 1. It is divided by 8 when control bit 10 is 0.
- R6: With control bit 9 = 1 (free-run), the counter keeps counting through a compare match and wraps from all ones to 0. Matching is modular, so a compare value just below the current count matches only after nearly a full period.
- R7: With control bit 9 = 0 (restart), an advance made while the counter equals the compare value loads 0.
- R8: Status bit 0 sets in the cycle after an advance that brings the counter to the compare value. Writing 1 to status bit 0 clears it, and writing 0 leaves it alone. When a set and a clear fall in the same cycle, the set wins.
- R9: `irq_o` is high exactly while status bit 0 and interrupt-enable bit 0 are both 1.
- R10: Register map: control 0x00 (bits 0, 3 and 6 to 10 kept), prescaler 0x04 (bits 15:0 kept), status 0x08, interrupt enable 0x0C (bit 0 kept), compare 0x10 (32 bits), counter 0x24 (read-only, zero-extended). Other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_bus | input | 1 | Bus clock source tick |
| tick_per | input | 1 | Peripheral clock source tick |
| tick_osc | input | 1 | Oscillator source tick |
| irq_o | output | 1 | Level interrupt |

## Verification
Directed sequences cover each source code against ticks on the other source inputs. This separates a correct source select from one that merges the inputs. Prescaler runs, one of them with a mid-count ratio change, tell a divider that restarts on the change from one that keeps its old phase. Runs through the counter wrap and with a compare value one below the current count separate modular matching from plain magnitude matching. A seeded random phase mixes register writes, tick patterns, mode switches and clears, and compares against a cycle model built from the requirements.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
   localparam int unsigned OFF_CTRL = 'h00;
   localparam int unsigned OFF_PRE  = 'h04;
   localparam int unsigned OFF_STAT = 'h08;
   localparam int unsigned OFF_IEN  = 'h0C;
   localparam int unsigned OFF_CMP  = 'h10;
   localparam int unsigned OFF_CNT  = 'h24;

   localparam int unsigned CTL_EN   = 0;
   localparam int unsigned CTL_WAIT = 3;
   localparam int unsigned CTL_SRC  = 6;
   localparam int unsigned CTL_FREE = 9;
   localparam int unsigned CTL_OSC  = 10;
   localparam logic [31:0] CTL_KEEP = 32'h0000_07C9;
   localparam logic [31:0] PRE_KEEP = 32'h0000_FFFF;

   localparam int unsigned PRE_MAIN_W  = 12;
   localparam int unsigned PRE_OSC_LSB = 12;
   localparam int unsigned PRE_OSC_W   = 4;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_BUS  = 3'd1,
      SRC_PER  = 3'd2,
      SRC_OSC  = 3'd5
   } src_e;
endpackage

// File: rtl/gpt_tick_div.sv
module gpt_tick_div #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] ratio,
   output logic         pulse
);
   logic [W-1:0] cnt_q;
   logic         at_end;

   if (W < 1 || W > 31) begin : g_bad_w
      $error("gpt_tick_div: W out of range");
   end

   assign at_end = (cnt_q >= ratio);
   assign pulse  = tick & ~clr & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (tick)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/gpt_clk_front.sv
module gpt_clk_front
   import gpt_pkg::*;
#(
   parameter int unsigned MAIN_W   = 12,
   parameter int unsigned OSC_W    = 4,
   parameter bit          OSC_PROG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [2:0]        src,
   input  logic              osc_en,
   input  logic [OSC_W-1:0]  osc_ratio,
   input  logic [MAIN_W-1:0] main_ratio,
   input  logic              osc_restart,
   input  logic              main_restart,
   input  logic              tick_bus,
   input  logic              tick_per,
   input  logic              tick_osc,
   output logic              adv
);
   localparam logic [OSC_W-1:0] FIXED_OSC = OSC_W'(7);

   logic             osc_tick, osc_pulse, src_tick, main_pulse;
   logic             osc_clr, main_clr;
   logic [OSC_W-1:0] osc_div_ratio;

   if (OSC_W < 3) begin : g_bad_osc
      $error("gpt_clk_front: OSC_W must hold the fixed divide of 8");
   end

   if (OSC_PROG) begin : g_osc_prog
      assign osc_div_ratio = osc_en ? osc_ratio : FIXED_OSC;
   end else begin : g_osc_fixed
      assign osc_div_ratio = FIXED_OSC;
   end

   assign osc_tick = tick_osc & (src == SRC_OSC);
   assign osc_clr  = ~en | osc_restart;
   assign main_clr = ~en | main_restart;

   gpt_tick_div #(.W(OSC_W)) u_osc_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (osc_clr),
      .tick  (osc_tick),
      .ratio (osc_div_ratio),
      .pulse (osc_pulse)
   );

   always_comb begin
      unique case (src)
         SRC_BUS: src_tick = tick_bus;
         SRC_PER: src_tick = tick_per;
         SRC_OSC: src_tick = osc_pulse;
         default: src_tick = 1'b0;
      endcase
   end

   gpt_tick_div #(.W(MAIN_W)) u_main_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (main_clr),
      .tick  (src_tick),
      .ratio (main_ratio),
      .pulse (main_pulse)
   );

   assign adv = en & main_pulse;
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             freerun,
   input  logic             adv,
   input  logic [31:0]      cmp,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o
);
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             flag_q, at_cmp, hit;

   assign at_cmp  = (32'(cnt_q) == cmp);
   assign cnt_nxt = (!freerun && at_cmp) ? '0 : cnt_q + 1'b1;
   assign hit     = en & adv & (32'(cnt_nxt) == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!en)   cnt_q <= '0;
      else if (adv)   cnt_q <= cnt_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (hit)       flag_q <= 1'b1;
      else if (flag_clr)  flag_q <= 1'b0;
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;

   assert_off_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt_q == '0) else $error("counter not held while disabled");
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en && !adv |=> $stable(cnt_q)) else $error("counter moved without a tick");
   assert_freerun_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      en && adv && freerun |=> cnt_q == $past(cnt_q) + 1'b1)
      else $error("free-run step wrong");
   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en && adv && !freerun && 32'(cnt_q) == cmp |=> cnt_q == '0)
      else $error("restart mode did not reload 0");
   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en && adv && 32'(cnt_nxt) == cmp |=> flag_q)
      else $error("match did not set flag");
endmodule

// File: rtl/gpt_cmp_timer.sv
module gpt_cmp_timer
   import gpt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 32,
   parameter bit          OSC_PROG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tick_bus,
   input  logic              tick_per,
   input  logic              tick_osc,
   output logic              irq_o
);
   localparam int unsigned MAIN_W = PRE_MAIN_W;
   localparam int unsigned OSC_W  = PRE_OSC_W;

   if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_addr
      $error("gpt_cmp_timer: ADDR_W must be 6..16");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("gpt_cmp_timer: CNT_W must be 2..32");
   end

   logic [31:0]       ctrl_q, pre_q, cmp_q;
   logic              ien_q;
   logic              wr, wr_ctrl, wr_pre, wr_stat, wr_ien, wr_cmp;
   logic              osc_restart, main_restart, adv, flag;
   logic [CNT_W-1:0]  cnt;

   assign wr      = bus_sel & bus_we;
   assign wr_ctrl = wr & (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_pre  = wr & (bus_addr == ADDR_W'(OFF_PRE));
   assign wr_stat = wr & (bus_addr == ADDR_W'(OFF_STAT));
   assign wr_ien  = wr & (bus_addr == ADDR_W'(OFF_IEN));
   assign wr_cmp  = wr & (bus_addr == ADDR_W'(OFF_CMP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pre_q  <= '0;
         ien_q  <= 1'b0;
         cmp_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata & CTL_KEEP;
         if (wr_pre)  pre_q  <= bus_wdata & PRE_KEEP;
         if (wr_ien)  ien_q  <= bus_wdata[0];
         if (wr_cmp)  cmp_q  <= bus_wdata;
      end
   end

   assign main_restart = wr_pre &
      (bus_wdata[MAIN_W-1:0] != pre_q[MAIN_W-1:0]);
   assign osc_restart  = wr_pre &
      (bus_wdata[PRE_OSC_LSB +: OSC_W] != pre_q[PRE_OSC_LSB +: OSC_W]);

   gpt_clk_front #(
      .MAIN_W   (MAIN_W),
      .OSC_W    (OSC_W),
      .OSC_PROG (OSC_PROG)
   ) u_front (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (ctrl_q[CTL_EN]),
      .src          (ctrl_q[CTL_SRC +: 3]),
      .osc_en       (ctrl_q[CTL_OSC]),
      .osc_ratio    (pre_q[PRE_OSC_LSB +: OSC_W]),
      .main_ratio   (pre_q[MAIN_W-1:0]),
      .osc_restart  (osc_restart),
      .main_restart (main_restart),
      .tick_bus     (tick_bus),
      .tick_per     (tick_per),
      .tick_osc     (tick_osc),
      .adv          (adv)
   );

   gpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q[CTL_EN]),
      .freerun  (ctrl_q[CTL_FREE]),
      .adv      (adv),
      .cmp      (cmp_q),
      .flag_clr (wr_stat & bus_wdata[0]),
      .cnt_o    (cnt),
      .flag_o   (flag)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_CTRL))      bus_rdata = ctrl_q;
      else if (bus_addr == ADDR_W'(OFF_PRE))  bus_rdata = pre_q;
      else if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = {31'b0, flag};
      else if (bus_addr == ADDR_W'(OFF_IEN))  bus_rdata = {31'b0, ien_q};
      else if (bus_addr == ADDR_W'(OFF_CMP))  bus_rdata = cmp_q;
      else if (bus_addr == ADDR_W'(OFF_CNT))  bus_rdata = 32'(cnt);
   end

   assign irq_o = flag & ien_q;

   assert_cmp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cmp |=> $stable(cmp_q)) else $error("compare changed without a write");
   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ien && !bus_wdata[0] |=> !irq_o) else $error("irq not masked");
endmodule

// File: tb/gpt_cmp_timer_test.sv
module gpt_cmp_timer_test;
   localparam int unsigned CW = 12;
   localparam logic [31:0] MSK = 32'h0000_0FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        tick_bus = 1'b0, tick_per = 1'b0, tick_osc = 1'b0;
   logic        irq_o;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   logic [31:0] m_ctrl, m_pre, m_cmp, m_cnt;
   logic        m_ien, m_flag;
   logic [3:0]  m_odiv;
   logic [11:0] m_mdiv;

   always #10 clk = ~clk;

   gpt_cmp_timer #(.ADDR_W(8), .CNT_W(CW), .OSC_PROG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_bus(tick_bus), .tick_per(tick_per), .tick_osc(tick_osc),
      .irq_o(irq_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b0; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // one clock of stimulus, with the reference model advanced alongside
   task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit tb, input bit tp, input bit to);
      logic en, fr, oen, wp, clr_o, clr_m, otk, op, stk, mp, hit;
      logic [2:0] src;
      logic [3:0] orat, n_odiv;
      logic [11:0] n_mdiv;
      logic [31:0] n_cnt, nxt, n_ctrl, n_pre, n_cmp;
      logic n_ien, n_flag;
      @(negedge clk);
      bus_sel = w; bus_we = w; bus_addr = a; bus_wdata = d;
      tick_bus = tb; tick_per = tp; tick_osc = to;
      en = m_ctrl[0]; src = m_ctrl[8:6]; fr = m_ctrl[9]; oen = m_ctrl[10];
      wp = w && a == 8'h04;
      clr_o = !en || (wp && d[15:12] != m_pre[15:12]);
      clr_m = !en || (wp && d[11:0] != m_pre[11:0]);
      otk = to && src == 3'd5;
      orat = oen ? m_pre[15:12] : 4'd7;
      op = otk && !clr_o && m_odiv >= orat;
      n_odiv = clr_o ? 4'd0 : otk ? (m_odiv >= orat ? 4'd0 : m_odiv + 4'd1) : m_odiv;
      stk = src == 3'd1 ? tb : src == 3'd2 ? tp : src == 3'd5 ? op : 1'b0;
      mp = stk && !clr_m && m_mdiv >= m_pre[11:0];
      n_mdiv = clr_m ? 12'd0 : stk ? (m_mdiv >= m_pre[11:0] ? 12'd0 : m_mdiv + 12'd1) : m_mdiv;
      hit = 1'b0; n_cnt = m_cnt;
      if (!en) n_cnt = 0;
      else if (mp) begin
         nxt = (!fr && m_cnt == m_cmp) ? 32'd0 : ((m_cnt + 1) & MSK);
         hit = (nxt == m_cmp);
         n_cnt = nxt;
      end
      n_flag = hit ? 1'b1 : (w && a == 8'h08 && d[0]) ? 1'b0 : m_flag;
      n_ctrl = (w && a == 8'h00) ? (d & 32'h7C9) : m_ctrl;
      n_pre  = wp ? (d & 32'hFFFF) : m_pre;
      n_ien  = (w && a == 8'h0C) ? d[0] : m_ien;
      n_cmp  = (w && a == 8'h10) ? d : m_cmp;
      @(posedge clk); #1;
      m_ctrl = n_ctrl; m_pre = n_pre; m_ien = n_ien; m_cmp = n_cmp;
      m_cnt = n_cnt; m_flag = n_flag; m_odiv = n_odiv; m_mdiv = n_mdiv;
      bus_sel = 1'b0; bus_we = 1'b0;
      tick_bus = 1'b0; tick_per = 1'b0; tick_osc = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic ticks(input int n, input bit tb, input bit tp, input bit to);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 32'h0, tb, tp, to);
   endtask

   task automatic cmp_model(input string req);
      logic [31:0] d;
      rd(8'h24, d); check({req, " counter"}, d, m_cnt);
      rd(8'h08, d); check({req, " status"}, d, {31'b0, m_flag});
      check({req, " irq"}, {31'b0, irq_o}, {31'b0, m_flag & m_ien});
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd7321));
      m_ctrl = 0; m_pre = 0; m_cmp = 0; m_cnt = 0; m_ien = 0; m_flag = 0;
      m_odiv = 0; m_mdiv = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: reset values
      rd(8'h00, d); check("R1 ctrl", d, 0);
      rd(8'h04, d); check("R1 prescaler", d, 0);
      rd(8'h08, d); check("R1 status", d, 0);
      rd(8'h0C, d); check("R1 ien", d, 0);
      rd(8'h10, d); check("R1 cmp", d, 0);
      rd(8'h24, d); check("R1 counter", d, 0);
      check("R1 irq", {31'b0, irq_o}, 0);

      // R10: map, masks, read-only counter, unmapped space
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R10 ctrl mask", d, 32'h7C9);
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check("R10 prescaler mask", d, 32'hFFFF);
      wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); check("R10 ien mask", d, 1);
      wr(8'h10, 32'hA5A5_1234); rd(8'h10, d); check("R10 cmp", d, 32'hA5A5_1234);
      wr(8'h24, 32'h0000_0123); rd(8'h24, d); check("R10 counter read-only", d, 0);
      wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, d); check("R10 unmapped", d, 0);
      // R3: code 7 gives no ticks even with all inputs pulsing
      ticks(5, 1, 1, 1); rd(8'h24, d); check("R3 code 7 idle", d, 0);
      wr(8'h00, 0); wr(8'h04, 0); wr(8'h10, 7);

      // R3, R8, R9: bus source, then peripheral source
      wr(8'h00, 32'h241);
      ticks(4, 1, 0, 0); rd(8'h24, d); check("R3 bus ticks", d, 4);
      ticks(3, 0, 1, 1); rd(8'h24, d); check("R3 other inputs ignored", d, 4);
      wr(8'h00, 32'h281);
      ticks(3, 0, 1, 0); rd(8'h24, d); check("R3 peripheral ticks", d, 7);
      rd(8'h08, d); check("R8 flag on match", d, 1);
      check("R9 irq on", {31'b0, irq_o}, 1);
      wr(8'h0C, 0); check("R9 irq masked", {31'b0, irq_o}, 0);
      wr(8'h08, 0); rd(8'h08, d); check("R8 write 0 keeps flag", d, 1);
      wr(8'h08, 1); rd(8'h08, d); check("R8 write 1 clears", d, 0);
      wr(8'h0C, 1); wr(8'h10, 8);
      step(1'b1, 8'h08, 32'h1, 0, 1, 0);
      rd(8'h08, d); check("R8 set wins over clear", d, 1);
      check("R9 irq again", {31'b0, irq_o}, 1);
      wr(8'h08, 1);

      // R7: restart mode
      wr(8'h10, 10); wr(8'h00, 32'h81);
      ticks(4, 0, 1, 0); rd(8'h24, d); check("R7 reload after match", d, 1);
      cmp_model("R7"); wr(8'h08, 1);

      // R2: disable clears and holds
      wr(8'h00, 32'h240); ticks(3, 1, 0, 0); rd(8'h24, d); check("R2 disabled holds 0", d, 0);

      // R4: main prescaler and restart on change
      wr(8'h04, 2); wr(8'h00, 32'h241);
      ticks(9, 1, 0, 0); rd(8'h24, d); check("R4 divide by 3", d, 3);
      ticks(2, 1, 0, 0);
      wr(8'h04, 3);
      ticks(3, 1, 0, 0); rd(8'h24, d); check("R4 restart no early tick", d, 3);
      ticks(1, 1, 0, 0); rd(8'h24, d); check("R4 divide by 4 after change", d, 4);

      // R5: oscillator fixed /8 and programmable /(N+1)
      wr(8'h00, 0); wr(8'h04, 0); wr(8'h00, 32'h341);
      ticks(16, 0, 0, 1); rd(8'h24, d); check("R5 fixed divide by 8", d, 2);
      ticks(4, 1, 1, 0); rd(8'h24, d); check("R3 osc code ignores others", d, 2);
      wr(8'h00, 0); wr(8'h04, 32'h3000); wr(8'h00, 32'h741);
      ticks(12, 0, 0, 1); rd(8'h24, d); check("R5 divide by N+1", d, 3);

      // R6: wrap and modular match
      wr(8'h00, 0); wr(8'h04, 0); wr(8'h08, 1); wr(8'h10, 32'hFFF); wr(8'h00, 32'h241);
      ticks(4095, 1, 0, 0); rd(8'h24, d); check("R6 reach all ones", d, 32'hFFF);
      rd(8'h08, d); check("R8 match at all ones", d, 1);
      wr(8'h08, 1);
      ticks(1, 1, 0, 0); rd(8'h24, d); check("R6 wrap to 0", d, 0);
      ticks(5, 1, 0, 0); wr(8'h10, 4);
      ticks(4094, 1, 0, 0); rd(8'h08, d); check("R6 no early match", d, 0);
      rd(8'h24, d); check("R6 count before match", d, 3);
      ticks(1, 1, 0, 0); rd(8'h08, d); check("R6 match after full period", d, 1);

      // random phase against the model (R2..R9)
      for (int i = 0; i < 6000; i++) begin
         int r;
         logic [7:0] a;
         logic [31:0] v;
         r = $urandom % 12;
         v = $urandom;
         if (r == 0) begin
            case ($urandom % 7)
               0: begin
                  a = 8'h00;
                  v[0] = ($urandom % 6) != 0;
                  case ($urandom % 4)
                     0: v[8:6] = 3'd1; 1: v[8:6] = 3'd2; 2: v[8:6] = 3'd5; default: v[8:6] = 3'd3;
                  endcase
               end
               1: begin a = 8'h04; v = v & 32'h3003; end
               2: a = 8'h08;
               3: a = 8'h0C;
               4: begin a = 8'h10; v = v % 40; end
               5: a = 8'h24;
               default: a = 8'h2C;
            endcase
            step(1'b1, a, v, v[20], v[21], v[22]);
         end else begin
            step(1'b0, 8'h00, 0, v[0] | v[1], v[2], v[3] | v[4]);
         end
         if (i % 40 == 39) cmp_model("R8 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule